// File: doc/BRIEF.md
# Serial-Clocked Conversion Word Output Port

This block is the output side of a converter that has no clock of its own besides the serial clock. Both the conversion timing and the data shift run from that clock. A counter in the block marks the end of each conversion cycle. At that moment the parallel sample supplied by a data source is captured as a 24-bit word. The top bit of the captured word is always cleared, because the low level it produces on the serial line also serves as the data-ready indication.

When a word is waiting and the select input is low, the serial data line drops on a rising clock edge. The host then samples on rising edges, and the block moves to the next bit on falling edges. The first bit therefore lasts one and a half clock periods, and 24 rising edges collect the whole word, MSB first. While the select input is high, the data line is released: the output enable is deasserted, which models the high-impedance state. A word that arrives while the host is deselected is held until the host selects the part. A conversion that lands during a read is thrown away. Raising select in the middle of a read abandons the word.

Top module: `sclk_word_port`

## Requirements
- R1: `sdo_oe` is the inverse of `cs_n` at all times, including during reset.
- R2: At the rising edge that ends a conversion while `cs_n` is low, `sdo` goes low and `rdy` goes high at that same edge.
- R3: After the edge of R2, `sdo` stays low through the next rising edge, so the first bit is one and a half clock periods wide.
- R4: The captured word is `sample_in` with bit 23 forced to 0, taken at the conversion edge. Its 24 bits appear MSB first, one bit before each of the 24 rising edges that follow the ready edge.
- R5: While a word is being shifted, `sdo` changes only on falling edges of `sclk`.
- R6: With no unread word, `sdo` is high and `rdy` is low. After the 24th data bit, `sdo` returns high at the next falling edge, and `rdy` clears at the rising edge after that.
- R7: A conversion that ends while `cs_n` is high is held with `rdy` high. A later conversion replaces it. The read starts (R2 behaviour) at the first rising edge that sees `cs_n` low.
- R8: A conversion that ends while a read is in progress does not change the word being shifted and is lost.
- R9: `cs_n` high during a read abandons the word. `rdy` clears at that edge, and the word is never offered again.
- R10: Conversions end every `CONV_CYCLES` rising edges. The first one ends at rising edge number `CONV_CYCLES` after reset is released.
- R11: Synchronous active-high reset clears any word and the conversion count, leaving `rdy` low and `sdo` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; also the conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sample_in | input | WORD_W | Parallel sample from the data source |
| sdo | output | 1 | Serial data / ready indication |
| sdo_oe | output | 1 | Output enable; low models high impedance |
| rdy | output | 1 | An unread word is held or being shifted |

## Verification
The main function is exercised in four situations:
- A conversion with select held low, which shows the immediate ready edge, the widened first bit and falling-edge bit changes.
- A conversion arriving while deselected and then overwritten, which separates holding from replacing.
- A late read that overlaps the next conversion, which shows whether the shifted word stays intact.
- A read cut short by select, which shows that the word is dropped and not offered again.

The stub pattern sets the top input bit on every sample, so a missing clear of the marker bit shows up in every frame.

// File: rtl/sclk_word_port_pkg.sv
package sclk_word_port_pkg;

    localparam int DEF_WORD_W      = 24;
    localparam int DEF_CONV_CYCLES = 128;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_HELD = 2'd1,
        RD_SEND = 2'd2
    } rd_state_e;

    function automatic logic [31:0] marker_mask(input int width);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < width - 1; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CONV_CYCLES = sclk_word_port_pkg::DEF_CONV_CYCLES
) (
    input  logic sclk,
    input  logic rst,
    output logic conv_done
);
    localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign conv_done = (cnt == LAST);

    always_ff @(posedge sclk) begin
        if (rst)            cnt <= '0;
        else if (conv_done) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/word_ctrl.sv
module word_ctrl
    import sclk_word_port_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    localparam int IDX_W = $clog2(WORD_W + 1)
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] sample_in,
    output rd_state_e         state,
    output logic [IDX_W-1:0]  bit_idx,
    output logic [WORD_W-1:0] word_q
);
    localparam logic [31:0]       MASK32 = marker_mask(WORD_W);
    localparam logic [WORD_W-1:0] MASK   = MASK32[WORD_W-1:0];
    localparam logic [IDX_W-1:0]  LAST   = IDX_W'(WORD_W);

    logic busy;
    logic load;

    always_comb begin
        busy = (state == RD_SEND) && !cs_n;
        load = conv_done && !busy;
    end

    always_ff @(posedge sclk) begin
        if (rst) begin
            state   <= RD_IDLE;
            bit_idx <= '0;
            word_q  <= '0;
        end else if (load) begin
            word_q  <= sample_in & MASK;
            state   <= cs_n ? RD_HELD : RD_SEND;
            bit_idx <= '0;
        end else begin
            unique case (state)
                RD_HELD: begin
                    if (!cs_n) begin
                        state   <= RD_SEND;
                        bit_idx <= '0;
                    end
                end
                RD_SEND: begin
                    if (cs_n || bit_idx == LAST) begin
                        state   <= RD_IDLE;
                        bit_idx <= '0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: begin
                    state   <= RD_IDLE;
                    bit_idx <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/sdo_driver.sv
module sdo_driver
    import sclk_word_port_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    localparam int IDX_W = $clog2(WORD_W + 1)
) (
    input  logic              sclk,
    input  logic              rst,
    input  rd_state_e         state,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [WORD_W-1:0] word_q,
    output logic              sdo
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W);

    logic [WORD_W-1:0] shifted;
    logic              lvl;
    logic              flag_phase;

    always_comb begin
        shifted    = word_q << bit_idx;
        flag_phase = (state == RD_SEND) && (bit_idx == '0);
        sdo        = flag_phase ? 1'b0 : lvl;
    end

    always_ff @(negedge sclk) begin
        if (rst)
            lvl <= 1'b1;
        else if (state == RD_SEND && bit_idx < LAST)
            lvl <= shifted[WORD_W-1];
        else
            lvl <= 1'b1;
    end
endmodule

// File: rtl/sclk_word_port.sv
module sclk_word_port
    import sclk_word_port_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int CONV_CYCLES = DEF_CONV_CYCLES,
    localparam int IDX_W      = $clog2(WORD_W + 1)
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [WORD_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              rdy
);
    logic              conv_done;
    rd_state_e         state;
    logic [IDX_W-1:0]  bit_idx;
    logic [WORD_W-1:0] word_q;

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .sclk      (sclk),
        .rst       (rst),
        .conv_done (conv_done)
    );

    word_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .sclk      (sclk),
        .rst       (rst),
        .cs_n      (cs_n),
        .conv_done (conv_done),
        .sample_in (sample_in),
        .state     (state),
        .bit_idx   (bit_idx),
        .word_q    (word_q)
    );

    sdo_driver #(.WORD_W(WORD_W)) u_drv (
        .sclk    (sclk),
        .rst     (rst),
        .state   (state),
        .bit_idx (bit_idx),
        .word_q  (word_q),
        .sdo     (sdo)
    );

    assign sdo_oe = !cs_n;
    assign rdy    = (state != RD_IDLE);
endmodule

// File: rtl/sclk_word_port_chk.sv
module sclk_word_port_chk
    import sclk_word_port_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int CONV_CYCLES = DEF_CONV_CYCLES,
    localparam int IDX_W      = $clog2(WORD_W + 1)
) (
    input logic              sclk,
    input logic              rst,
    input logic              cs_n,
    input logic              sdo,
    input logic              conv_done,
    input rd_state_e         state,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [WORD_W-1:0] word_q
);
    // R6: an idle port keeps the line high
    p_idle_high_r6: assert property (@(posedge sclk) disable iff (rst)
        (state == RD_IDLE && $past(state) == RD_IDLE) |-> sdo);

    // R8: the word under shift is never overwritten
    p_word_stable_r8: assert property (@(posedge sclk) disable iff (rst)
        (state == RD_SEND && $past(state) == RD_SEND) |-> $stable(word_q));

    // R4: the bit index never passes the word length
    p_idx_bound_r4: assert property (@(posedge sclk) disable iff (rst)
        bit_idx <= IDX_W'(WORD_W));

    // R9: deselect during a read ends the read
    p_abort_r9: assert property (@(posedge sclk) disable iff (rst)
        (state == RD_SEND && cs_n) |=> (state != RD_SEND));

    // R7: a held word starts shifting once selected
    p_held_start_r7: assert property (@(posedge sclk) disable iff (rst)
        (state == RD_HELD && !cs_n && !conv_done) |=> (state == RD_SEND && bit_idx == '0));

    // R10: conversion ends are isolated pulses
    p_conv_gap_r10: assert property (@(posedge sclk) disable iff (rst)
        conv_done |=> !conv_done);
endmodule

bind sclk_word_port sclk_word_port_chk #(
    .WORD_W      (WORD_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .sclk      (sclk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sdo       (sdo),
    .conv_done (conv_done),
    .state     (state),
    .bit_idx   (bit_idx),
    .word_q    (word_q)
);

// File: tb/sclk_word_port_test.sv
`timescale 1ns/1ps
module sclk_word_port_test;
    localparam int W    = 24;
    localparam int CONV = 48;

    logic         clk = 1'b0;
    logic         rst;
    logic         cs_n;
    logic [W-1:0] sample_in = '0;
    logic         sdo, sdo_oe, rdy;

    int vectors = 0;
    int miscompares = 0;
    int n = 0;
    int frames_seen = 0;
    bit finished = 0;
    logic [W-1:0] exp_q[$];

    sclk_word_port #(.WORD_W(W), .CONV_CYCLES(CONV)) uut (
        .sclk(clk), .rst(rst), .cs_n(cs_n), .sample_in(sample_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .rdy(rdy)
    );

    always #4 clk = ~clk;

    always @(posedge clk) n <= rst ? 0 : n + 1;

    function automatic logic [W-1:0] stub(int v);
        return 24'hB00000 ^ 24'(v * 32'h1357);
    endfunction

    function automatic logic [W-1:0] conv_word(int k);
        return stub(CONV * k - 1) & 24'h7FFFFF;
    endfunction

    always @(posedge clk) begin
        #2 sample_in = stub(n);
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at n=%0d", tag, act, exp, n);
        end
    endtask

    task automatic expect_conv(int k);
        exp_q.push_back(conv_word(k));
    endtask

    task automatic wait_n(int t);
        while (n != t) begin
            @(posedge clk);
            #2;
        end
    endtask

    // monitor: samples the line one ns before each rising edge
    initial begin
        bit in_frame = 0;
        int got = 0;
        logic [W-1:0] acc = '0;
        logic [W-1:0] e;
        forever begin
            @(negedge clk);
            #3;
            if (rst) begin
                in_frame = 0;
            end else if (in_frame) begin
                if (!sdo_oe) begin
                    in_frame = 0;
                end else begin
                    acc = {acc[W-2:0], sdo};
                    got++;
                    if (got == W) begin
                        in_frame = 0;
                        frames_seen++;
                        if (exp_q.size() == 0) begin
                            check("R4 unexpected frame", 32'(acc), 32'hFFFFFFFF);
                        end else begin
                            e = exp_q.pop_front();
                            check("R4 word MSB first", 32'(acc), 32'(e));
                        end
                    end
                end
            end else if (sdo_oe && sdo === 1'b0) begin
                in_frame = 1;
                acc = '0;
                got = 1;
            end
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w1;
        rst = 1'b1;
        cs_n = 1'b1;
        repeat (4) @(posedge clk);
        #2;
        check("R1 oe during reset", 32'(sdo_oe), 32'd0);
        check("R11 rdy during reset", 32'(rdy), 32'd0);
        rst = 1'b0;
        cs_n = 1'b0;

        wait_n(10);
        check("R1 oe selected", 32'(sdo_oe), 32'd1);
        check("R6 line high before data", 32'(sdo), 32'd1);
        check("R11 rdy after reset", 32'(rdy), 32'd0);

        w1 = conv_word(1);
        wait_n(47);
        check("R10 no conversion yet", 32'(rdy), 32'd0);
        expect_conv(1);
        wait_n(48);
        check("R10 conversion at edge CONV", 32'(rdy), 32'd1);
        check("R2 line low at ready edge", 32'(sdo), 32'd0);
        wait_n(49);
        check("R3 first bit still low", 32'(sdo), 32'd0);
        wait_n(50);
        check("R5 bit22 held across rise", 32'(sdo), 32'(w1[22]));
        #3;
        check("R5 bit21 after fall", 32'(sdo), 32'(w1[21]));

        wait_n(74);
        check("R6 line high after frame", 32'(sdo), 32'd1);
        check("R6 rdy clear after frame", 32'(rdy), 32'd0);

        wait_n(90);
        cs_n = 1'b1;
        wait_n(100);
        check("R7 held word flags rdy", 32'(rdy), 32'd1);
        check("R1 oe deselected", 32'(sdo_oe), 32'd0);
        expect_conv(3);
        wait_n(150);
        check("R7 replaced word still held", 32'(rdy), 32'd1);
        wait_n(180);
        cs_n = 1'b0;
        wait_n(181);
        check("R7 read starts on select", 32'(sdo), 32'd0);

        wait_n(210);
        check("R8 overlapping conversion lost rdy", 32'(rdy), 32'd0);
        check("R8 overlapping conversion lost sdo", 32'(sdo), 32'd1);
        expect_conv(5);

        wait_n(298);
        cs_n = 1'b1;
        wait_n(300);
        check("R9 abort clears rdy", 32'(rdy), 32'd0);
        check("R1 oe after abort", 32'(sdo_oe), 32'd0);
        wait_n(305);
        cs_n = 1'b0;
        wait_n(310);
        check("R9 abandoned word not resent sdo", 32'(sdo), 32'd1);
        check("R9 abandoned word not resent rdy", 32'(rdy), 32'd0);
        expect_conv(7);

        wait_n(370);
        check("R4 frames received", 32'(frames_seen), 32'd4);
        check("R8 no pending expected words", 32'(exp_q.size()), 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule